// File: doc/BRIEF.md
# Region coherence command sequencer

The runtime issues one command that names a contiguous data region and a sharing hint. The sequencer turns that command into a series of per-block coherence requests for a private cache. The cache keeps coherence through a directory-based MESI protocol.

The region is given as a base address and a length counted in cache blocks. The sequencer starts at the block that holds the base address and walks upward one block at a time. It issues exactly one request per block. The request kind comes straight from the hint:

- For producer-consumer sharing, the producer's copies are downgraded so that consumers can read them without a remote fetch.
- For migratory sharing, the holder downgrades and also self-invalidates each block.
- For consumer-side use, each block is prefetched to hide last-level cache latency.

Only one command is handled at a time. Completion is signalled by a single-cycle done pulse.

Top module: `region_coh_seq`

## Requirements
- R1: After reset, cmd_ready is 1, req_valid is 0 and done is 0.
- R2: Every request carries req_kind equal to the command's op code: 00 downgrade, 01 downgrade plus self-invalidate, 10 prefetch.
- R3: While req_valid is 1 and req_ready is 0, req_valid stays 1 and req_addr and req_kind hold their values into the next cycle.
- R4: A command with length N and op 00, 01 or 10 issues exactly N requests. Their addresses are A, A+64, A+128 and so on upward, where A is the base address. Each address advances only after a completed valid/ready handshake.
- R5: cmd_ready is 0 from the cycle after a command is accepted up to and including the done cycle. cmd_valid together with any command fields is ignored in that period.
- R6: done is 1 for exactly one cycle, in the cycle right after the handshake of the final request. cmd_ready returns to 1 in the cycle after done.
- R7: A command with length 0 issues no request, and done is 1 in the cycle right after acceptance.
- R8: Op code 11 is a no-op: no request is issued whatever the length, and done is 1 in the cycle right after acceptance.
- R9: The six low bits of the base address are ignored. The first request goes to the base rounded down to a 64-byte boundary, and every request address has its six low bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_base | input | ADDR_W | Region base byte address |
| cmd_len | input | LEN_W | Region length in blocks |
| cmd_op | input | 2 | Sharing hint: 00 downgrade, 01 downgrade plus self-invalidate, 10 prefetch, 11 no-op |
| req_valid | output | 1 | Per-block request valid |
| req_ready | input | 1 | Cache controller accepts the request |
| req_addr | output | ADDR_W | Block address of the request |
| req_kind | output | 2 | Coherence action, same encoding as cmd_op |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a request that the cache leaves waiting for several cycles while the runtime keeps offering new commands. That stall must neither move the address nor let a second command slip in. The bench's cache responder draws req_ready from a shift-register sequence, so stalls of varied length fall on first, middle and last blocks. In one scenario the bench also holds cmd_valid high with junk fields for the whole run. Done timing is measured against the cycle of the last handshake as the responder logged it, not against a fixed count.

// File: rtl/region_coh_seq.sv
module region_coh_seq #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BLK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [1:0]        cmd_op,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_kind,
  output logic              done
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t              st;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  left;
  logic [1:0]        kind;

  wire accept = cmd_valid && cmd_ready;
  wire fire   = req_valid && req_ready;
  wire skip   = (cmd_len == '0) || (cmd_op == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      addr <= '0;
      left <= '0;
      kind <= 2'b00;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          addr <= {cmd_base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
          left <= cmd_len;
          kind <= cmd_op;
          st   <= skip ? S_FIN : S_RUN;
        end
        S_RUN: if (fire) begin
          addr <= addr + ADDR_W'(BLK_BYTES);
          left <= left - 1'b1;
          if (left == LEN_W'(1)) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == S_IDLE);
  assign req_valid = (st == S_RUN);
  assign req_addr  = addr;
  assign req_kind  = kind;
  assign done      = (st == S_FIN);
endmodule

// File: rtl/region_coh_seq_chk.sv
module region_coh_seq_chk #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BLK_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [LEN_W-1:0]  cmd_len,
  input logic [1:0]        cmd_op,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_kind,
  input logic              done
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  a_r2_kind_steady: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && $past(req_valid) |-> $stable(req_kind));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_kind));

  a_r4_stride: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid || (req_addr == $past(req_addr) + ADDR_W'(BLK_BYTES)));

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  a_r5_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_ready && !req_valid);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);

  a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_len == '0 |=> done && !req_valid);

  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'b11 |=> done && !req_valid);

  a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[OFF_W-1:0] == '0);
endmodule

bind region_coh_seq region_coh_seq_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_len(cmd_len), .cmd_op(cmd_op), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_kind(req_kind), .done(done)
);

// File: tb/region_coh_seq_tb.sv
module region_coh_seq_tb;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              cmd_valid = 0;
  logic              cmd_ready;
  logic [ADDR_W-1:0] cmd_base = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic [1:0]        cmd_op = 2'b00;
  logic              req_valid;
  logic              req_ready = 0;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_kind;
  logic              done;

  region_coh_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_len(cmd_len), .cmd_op(cmd_op),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_kind(req_kind), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cache responder and request log
  bit                stall_on = 0;
  logic [15:0]       lfsr = 16'hACE1;
  logic [ADDR_W-1:0] log_addr [0:63];
  logic [1:0]        log_kind [0:63];
  int                log_n = 0;
  int                hs_cyc = -10;
  int                hold_err = 0;
  bit                prev_wait = 0;
  logic [ADDR_W-1:0] prev_addr;
  logic [1:0]        prev_kind;

  always @(negedge clk) begin
    if (prev_wait && !(req_valid && req_addr == prev_addr && req_kind == prev_kind))
      hold_err++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    req_ready = stall_on ? lfsr[0] : 1'b1;
    if (req_valid && req_ready) begin
      if (log_n < 64) begin
        log_addr[log_n] = req_addr;
        log_kind[log_n] = req_kind;
      end
      log_n++;
      hs_cyc = cyc;
    end
    prev_wait = req_valid && !req_ready;
    prev_addr = req_addr;
    prev_kind = req_kind;
  end

  task automatic run(input logic [ADDR_W-1:0] base, input int len,
                     input logic [1:0] op, input bit stall, input bit junk);
    int n_exp;
    int waited;
    logic [ADDR_W-1:0] a0;
    n_exp = (len == 0 || op == 2'b11) ? 0 : len;
    a0 = base & ~ADDR_W'(63);
    @(negedge clk);
    stall_on = stall;
    log_n = 0; hold_err = 0; hs_cyc = -10;
    cmd_valid = 1; cmd_base = base; cmd_len = LEN_W'(len); cmd_op = op;
    chk(cmd_ready == 1'b1, "R5", "ready before command", cmd_ready, 1);
    @(negedge clk);
    waited = 1;
    if (junk) begin
      cmd_base = 32'hDEAD_0000; cmd_len = 16'd3; cmd_op = 2'b10;
    end else cmd_valid = 0;
    while (!done && waited < 5000) begin
      chk(cmd_ready == 1'b0, "R5", "ready low while busy", cmd_ready, 0);
      @(negedge clk);
      waited++;
    end
    cmd_valid = 0;
    chk(done == 1'b1, "R6", "done seen before timeout", done, 1);
    chk(cmd_ready == 1'b0, "R5", "ready low in done cycle", cmd_ready, 0);
    if (n_exp == 0)
      chk(waited == 1, (op == 2'b11) ? "R8" : "R7", "done delay after accept", waited, 1);
    else
      chk(cyc == hs_cyc + 1, "R6", "done one cycle after final handshake", cyc, hs_cyc + 1);
    chk(log_n == n_exp, "R4", "request count", log_n, n_exp);
    for (int i = 0; i < n_exp && i < log_n && i < 64; i++) begin
      chk(log_addr[i] == a0 + ADDR_W'(64 * i), (base[5:0] != 0) ? "R9" : "R4",
          "request address", log_addr[i], a0 + ADDR_W'(64 * i));
      chk(log_kind[i] == op, "R2", "request kind", log_kind[i], op);
    end
    chk(hold_err == 0, "R3", "stalled request held", hold_err, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done single cycle", done, 0);
    chk(cmd_ready == 1'b1, "R6", "ready back after done", cmd_ready, 1);
    chk(log_n == n_exp, "R5", "no extra request after done", log_n, n_exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
    chk(req_valid == 1'b0, "R1", "req_valid after reset", req_valid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
  endtask

  task automatic t_downgrade;       run(32'h0000_1000, 4, 2'b00, 0, 0); endtask
  task automatic t_migratory;       run(32'h0004_0040, 5, 2'b01, 1, 0); endtask
  task automatic t_prefetch_unalig; run(32'h0000_2027, 3, 2'b10, 1, 0); endtask
  task automatic t_zero_len;        run(32'h0000_3000, 0, 2'b00, 0, 0); endtask
  task automatic t_reserved;        run(32'h0000_4000, 6, 2'b11, 0, 1); endtask
  task automatic t_single;          run(32'h0000_507F, 1, 2'b01, 1, 0); endtask
  task automatic t_junk_busy;       run(32'h0001_0000, 8, 2'b00, 1, 1); endtask
  task automatic t_back_to_back;
    run(32'h0002_0000, 2, 2'b10, 0, 0);
    run(32'h0002_1000, 3, 2'b00, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_downgrade();
    t_migratory();
    t_prefetch_unalig();
    t_zero_len();
    t_reserved();
    t_single();
    t_junk_busy();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule